// File: doc/BRIEF.md
# Descriptor-Chained USB Packet Segmenter

This block is the transmit side of a USB data mover. Software builds a linked list of descriptors in a word memory and hands the address of the first one to the block with a start pulse. The first descriptor states how many bytes the whole transfer carries. Every descriptor names one byte buffer and its length, and points to the next descriptor. The block walks the list and reads the buffers byte by byte through a second memory port. It sends the bytes as a stream that is cut into packets no longer than a programmed maximum packet size.

In chained mode, packet boundaries depend only on the maximum packet size and the total length. A packet that straddles two buffers simply continues into the next one. In transparent mode, each buffer also closes the packet that holds its last byte, so one buffer carries at most one packet. At the end, a one-cycle done strobe returns the first descriptor's address so that it can be queued for completion. If the list ends before the promised length, the done strobe raises an error flag.

Top module: `usb_seg`

## Requirements
- R1: A start pulse while idle latches the first descriptor address, the maximum packet size and the mode, and raises busy. A start pulse while busy is ignored and does not alter the running transfer or the reported address.
- R2: A descriptor occupies four consecutive words at word address D. Word D holds the total transfer length in bits [15:0], and only the first descriptor's value is used. Word D+1 holds the buffer byte address, D+2 holds the buffer length in bits [15:0], and D+3 holds the next-descriptor word address, where 0 means none.
- R3: Exactly the total length of bytes is emitted, in buffer order and address order within each buffer. Bytes of the last buffer beyond the total are not sent.
- R4: With mode 0 (chained), every packet holds the maximum packet size except the last, which holds the remainder. A packet continues across a buffer boundary without a break. out_sop marks a packet's first byte and out_eop its last.
- R5: With mode 1 (transparent), the last byte of every buffer also carries out_eop. The maximum packet size and the final byte still close packets as in R4.
- R6: A descriptor whose buffer length is 0 contributes no bytes, and the walk moves on to its next descriptor.
- R7: After the last byte, done pulses for one cycle in the cycle after that byte's out_valid. It carries done_addr equal to the first descriptor address and done_err equal to 0.
- R8: If a buffer runs out with bytes still owed and its next pointer is 0, the transfer ends. No further bytes are sent, and done pulses with done_err equal to 1.
- R9: A total length of 0 ends the transfer after the first descriptor is read. No byte is emitted, and done pulses with done_err equal to 0.
- R10: Both memory ports return data one cycle after a read request. A byte requested in one cycle appears on out_data with out_valid in the next, and the two ports are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| start_addr | input | AW | Word address of the first descriptor |
| max_pkt | input | MW | Maximum packet size in bytes |
| xparent | input | 1 | 1 selects transparent mode, 0 chained mode |
| busy | output | 1 | Transfer in progress |
| desc_rd | output | 1 | Descriptor word read request |
| desc_addr | output | AW | Descriptor word address |
| desc_rdata | input | 32 | Descriptor word, one cycle after request |
| byte_rd | output | 1 | Data byte read request |
| byte_addr | output | AW | Data byte address |
| byte_rdata | input | 8 | Data byte, one cycle after request |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| done | output | 1 | Transfer finished, one-cycle pulse |
| done_addr | output | AW | First descriptor address, valid with done |
| done_err | output | 1 | Chain ended short, valid with done |

## Verification
Three events can land on the same byte: the packet filling up, the buffer running out, and the transfer's final byte. The bench builds chains where a 64-byte buffer ends exactly at a 64-byte packet boundary. It also builds chains where the total cuts inside a buffer, and transparent chains where buffer ends and packet ends coincide. For each of these, the scoreboard's independently computed sop/eop/data triples must match byte for byte. A start pulse is also injected in the middle of a transfer. This checks that an ignored start leaves both the stream and the reported done address untouched.

// File: rtl/usb_seg.sv
module usb_seg #(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int MW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [MW-1:0] max_pkt,
  input  logic          xparent,
  output logic          busy,
  output logic          desc_rd,
  output logic [AW-1:0] desc_addr,
  input  logic [31:0]   desc_rdata,
  output logic          byte_rd,
  output logic [AW-1:0] byte_addr,
  input  logic [7:0]    byte_rdata,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic          done,
  output logic [AW-1:0] done_addr,
  output logic          done_err
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_STREAM, S_FIN} st_t;
  localparam logic [2:0] LAST_WORD = 3'd4;

  st_t           st;
  logic [2:0]    cnt;
  logic [AW-1:0] cur, head, baddr, nxt;
  logic [LW-1:0] rem, blen;
  logic [MW-1:0] maxp_r, pcnt;
  logic          first, xp_r, err_r;

  wire last_all = (rem == LW'(1));
  wire last_buf = (blen == LW'(1));
  wire pkt_full = ((pcnt + MW'(1)) == maxp_r);
  wire eop_i    = last_all | pkt_full | (xp_r & last_buf);
  wire [AW-1:0] link = desc_rdata[AW-1:0];

  assign busy      = (st != S_IDLE);
  assign desc_rd   = (st == S_FETCH) && (cnt < LAST_WORD);
  assign desc_addr = cur + AW'(cnt);
  assign byte_rd   = (st == S_STREAM);
  assign byte_addr = baddr;
  assign out_data  = byte_rdata;
  assign done_addr = head;
  assign done_err  = err_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; cur <= '0; head <= '0; baddr <= '0; nxt <= '0;
      rem <= '0; blen <= '0; maxp_r <= '0; pcnt <= '0; first <= 1'b0;
      xp_r <= 1'b0; err_r <= 1'b0; out_valid <= 1'b0; out_sop <= 1'b0;
      out_eop <= 1'b0; done <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cur <= start_addr; head <= start_addr; first <= 1'b1;
          maxp_r <= max_pkt; xp_r <= xparent; cnt <= '0; err_r <= 1'b0;
          pcnt <= '0; rem <= '0; st <= S_FETCH;
        end
        S_FETCH: begin
          cnt <= cnt + 3'd1;
          case (cnt)
            3'd1: if (first) rem <= desc_rdata[LW-1:0];
            3'd2: baddr <= desc_rdata[AW-1:0];
            3'd3: blen <= desc_rdata[LW-1:0];
            3'd4: begin
              first <= 1'b0;
              cnt   <= '0;
              nxt   <= link;
              if (rem == '0) st <= S_FIN;
              else if (blen == '0) begin
                if (link == '0) begin err_r <= 1'b1; st <= S_FIN; end
                else cur <= link;
              end else st <= S_STREAM;
            end
            default: ;
          endcase
        end
        S_STREAM: begin
          out_valid <= 1'b1;
          out_sop   <= (pcnt == '0);
          out_eop   <= eop_i;
          baddr     <= baddr + AW'(1);
          blen      <= blen - LW'(1);
          rem       <= rem - LW'(1);
          pcnt      <= eop_i ? '0 : pcnt + MW'(1);
          if (last_all) st <= S_FIN;
          else if (last_buf) begin
            if (nxt == '0) begin err_r <= 1'b1; st <= S_FIN; end
            else begin cur <= nxt; cnt <= '0; st <= S_FETCH; end
          end
        end
        S_FIN: begin done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic          open_pkt;
  logic [MW:0]   run_len;
  wire  [MW:0]   this_len = out_sop ? (MW+1)'(1) : run_len + (MW+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_pkt <= 1'b0; run_len <= '0;
    end else if (start && !busy) begin
      open_pkt <= 1'b0; run_len <= '0;
    end else if (out_valid) begin
      open_pkt <= !out_eop;
      run_len  <= out_eop ? '0 : this_len;
    end
  end

  p_ports_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_rd && byte_rd));
  p_valid_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(byte_rd));
  p_done_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid && !busy && $past(busy));
  p_sop_framing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sop == !open_pkt));
  p_pkt_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (this_len <= {1'b0, maxp_r}));
  p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(done_addr));
endmodule

// File: tb/usb_seg_tb.sv
module usb_seg_tb;
  localparam int AW = 16, LW = 16, MW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, xparent = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [MW-1:0] max_pkt = '0;
  logic busy, desc_rd, byte_rd, out_valid, out_sop, out_eop, done, done_err;
  logic [AW-1:0] desc_addr, byte_addr, done_addr;
  logic [31:0] desc_rdata;
  logic [7:0]  byte_rdata, out_data;

  logic [31:0] dmem [0:63];
  logic [7:0]  bmem [0:1023];

  always #10 clk = ~clk;

  usb_seg #(.AW(AW), .LW(LW), .MW(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .max_pkt(max_pkt), .xparent(xparent), .busy(busy),
    .desc_rd(desc_rd), .desc_addr(desc_addr), .desc_rdata(desc_rdata),
    .byte_rd(byte_rd), .byte_addr(byte_addr), .byte_rdata(byte_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .done(done), .done_addr(done_addr), .done_err(done_err));

  always_ff @(posedge clk) begin
    if (desc_rd) desc_rdata <= dmem[desc_addr[5:0]];
    if (byte_rd) byte_rdata <= bmem[byte_addr[9:0]];
  end

  int checks = 0, errors = 0;
  logic [9:0] expq [$];
  logic [9:0] e;
  logic [AW-1:0] exp_addr;
  logic exp_err, done_seen;
  string cur_req = "R3";
  int ba [0:7];
  int bl [0:7];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (expq.size() == 0)
        chk(1'b0, cur_req, "unexpected byte", int'(out_data), -1);
      else begin
        e = expq.pop_front();
        chk({out_sop, out_eop, out_data} == e, cur_req, "sop/eop/data",
            int'({out_sop, out_eop, out_data}), int'(e));
      end
    end
    if (done) begin
      done_seen = 1'b1;
      chk(done_addr == exp_addr, "R7", "done_addr", int'(done_addr), int'(exp_addr));
      chk(done_err == exp_err, exp_err ? "R8" : "R7", "done_err",
          int'(done_err), int'(exp_err));
    end
  end

  task automatic run(input string req, input int n, input int total,
                     input int mp, input bit xp, input bit poke);
    int rem = total, pc = 0, t = 0;
    bit eop, sop;
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      dmem[4 + 4*i]     = (i == 0) ? total : 32'h0000_BEEF;
      dmem[4 + 4*i + 1] = ba[i];
      dmem[4 + 4*i + 2] = bl[i];
      dmem[4 + 4*i + 3] = (i == n-1) ? 0 : 8 + 4*i;
    end
    for (int i = 0; i < n; i++)
      for (int j = 0; j < bl[i] && rem > 0; j++) begin
        sop = (pc == 0);
        eop = (pc + 1 == mp) || (rem == 1) || (xp && j == bl[i] - 1);
        expq.push_back({sop, eop, bmem[(ba[i] + j) % 1024]});
        pc = eop ? 0 : pc + 1;
        rem--;
      end
    exp_err = (rem > 0);
    exp_addr = 16'd4;
    done_seen = 1'b0;
    @(negedge clk);
    start = 1'b1; start_addr = 16'd4; max_pkt = MW'(mp); xparent = xp;
    @(negedge clk);
    start = 1'b0; start_addr = 16'd40; max_pkt = MW'(7); xparent = !xp;
    chk(busy, "R1", "busy after start", int'(busy), 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done_seen && t < 5000) begin @(negedge clk); t++; end
    chk(done_seen, req, "done seen", int'(done_seen), 1);
    chk(expq.size() == 0, req, "bytes missing", expq.size(), 0);
    expq.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 8'(i * 5 + 1);
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !done && !busy, "R1", "reset state",
        int'({out_valid, done, busy}), 0);
    // R3 R4: 130 bytes, 64-byte packets, buffer larger than total
    ba[0] = 100; bl[0] = 200;
    run("R3", 1, 130, 64, 1'b0, 1'b0);
    // R4 R2: packets straddle buffers of 32, 50, 60
    ba[0] = 10; bl[0] = 32; ba[1] = 300; bl[1] = 50; ba[2] = 600; bl[2] = 60;
    run("R4", 3, 130, 64, 1'b0, 1'b0);
    // R4: buffer end coincides with packet end
    ba[0] = 0; bl[0] = 64; ba[1] = 512; bl[1] = 64;
    run("R4", 2, 128, 64, 1'b0, 1'b0);
    // R4: 608 bytes in 64-byte pieces
    ba[0] = 200; bl[0] = 608;
    run("R4", 1, 608, 64, 1'b0, 1'b0);
    // R5: transparent, buffers close packets
    ba[0] = 5; bl[0] = 40; ba[1] = 400; bl[1] = 64; ba[2] = 700; bl[2] = 26;
    run("R5", 3, 130, 64, 1'b1, 1'b0);
    // R5: transparent buffer longer than max packet
    ba[0] = 50; bl[0] = 40;
    run("R5", 1, 40, 16, 1'b1, 1'b0);
    // R6: zero-length buffer in the middle
    ba[0] = 20; bl[0] = 10; ba[1] = 999; bl[1] = 0; ba[2] = 800; bl[2] = 30;
    run("R6", 3, 40, 16, 1'b0, 1'b0);
    // R8: chain ends short
    ba[0] = 30; bl[0] = 16; ba[1] = 90; bl[1] = 16;
    run("R8", 2, 64, 16, 1'b0, 1'b0);
    // R9: zero total
    ba[0] = 30; bl[0] = 16;
    run("R9", 1, 0, 16, 1'b0, 1'b0);
    // R1: start while busy is ignored
    ba[0] = 60; bl[0] = 100;
    run("R1", 1, 100, 32, 1'b0, 1'b1);
    // R10: one-byte transfer timing
    ba[0] = 77; bl[0] = 1;
    run("R10", 1, 1, 8, 1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule